// File: doc/BRIEF.md
# Atomic Set/Clear Register Bank

This block is a small bank of 32-bit peripheral registers, reached over two independent register ports. Each register can be reached at three word addresses. The primary address gives a plain read and a full-word write. The set alias ORs the write data into the register. The clear alias drops every bit that is 1 in the write data. An alias write changes only the bits its mask names, and it does so in the clock edge that takes the write. There is no read phase and no window in which another agent could slip in between.

Software updates a multi-bit field in two steps. It first clears the field mask through the clear alias, then sets the new value through the set alias. Between the two writes the field reads as zero. When both ports hit one register in the same cycle, the result is defined: a clear beats a set, and a set beats a plain write. Read data is registered. It shows the register value from before the edge, so it behaves like a block RAM with read-first ordering.

Top module: `alias_regs`

## Requirements
- R1: A synchronous active-high reset sets every register and both read-data outputs to zero.
- R2: A write to a primary address (PRI_BASE + n, defaults 0x00..0x07) replaces the whole word of register n.
- R3: A write to the set alias (SET_BASE + n, default 0x40 + n) sets each register bit whose write-data bit is 1 and leaves the other bits as they were, within one edge.
- R4: A write to the clear alias (CLR_BASE + n, default 0x80 + n) zeroes each register bit whose write-data bit is 1 and leaves the other bits as they were, within one edge.
- R5: A field written as a clear of its mask followed by a set of its value reads as zero between the two writes and holds the value after them, and bits outside the mask are kept.
- R6: A read at any of a register's three addresses, on either port, returns that register's value.
- R7: A write to an address outside the three windows changes no register, and a read there returns zero.
- R8: In the same cycle and on the same register, clear bits win over set bits and set bits win over plain writes. When both ports write the same primary address, port A's word is kept.
- R9: Read data appears one cycle after the address and carries the register value from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | ADDR_W | Port A word address |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | DATA_W | Port A write data or bit mask |
| a_rdata | output | DATA_W | Port A registered read data |
| b_addr | input | ADDR_W | Port B word address |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | DATA_W | Port B write data or bit mask |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The hardest case to reach is two ports hitting the same register in the same cycle with different kinds of write. A single-port access sequence never produces this, so the priority rule is never tested that way. The bench drives port A and port B from the same negative edge, with overlapping set and clear masks and with plain writes paired with sets. It then reads the word back to confirm that the bits were resolved in the required order. A read and a write issued together to one address also show the read-first timing.

// File: rtl/alias_regs_pkg.sv
package alias_regs_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_PRI  = 2'd1,
    RK_SET  = 2'd2,
    RK_CLR  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NREG     = 8,
  parameter int IDX_W    = 3,
  parameter int PRI_BASE = 'h00,
  parameter int SET_BASE = 'h40,
  parameter int CLR_BASE = 'h80
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  logic [ADDR_W-1:0] off_p, off_s, off_c;

  always_comb begin
    off_p = addr - ADDR_W'(PRI_BASE);
    off_s = addr - ADDR_W'(SET_BASE);
    off_c = addr - ADDR_W'(CLR_BASE);
    kind  = RK_NONE;
    idx   = '0;
    if (off_p < NREG_A) begin
      kind = RK_PRI;
      idx  = off_p[IDX_W-1:0];
    end else if (off_s < NREG_A) begin
      kind = RK_SET;
      idx  = off_s[IDX_W-1:0];
    end else if (off_c < NREG_A) begin
      kind = RK_CLR;
      idx  = off_c[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/alias_bank.sv
module alias_bank
  import alias_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         a_we,
  input  reg_kind_e                    a_kind,
  input  logic [IDX_W-1:0]             a_idx,
  input  logic [DATA_W-1:0]            a_wdata,
  input  logic                         b_we,
  input  reg_kind_e                    b_kind,
  input  logic [IDX_W-1:0]             b_idx,
  input  logic [DATA_W-1:0]            b_wdata,
  output logic [NREG-1:0][DATA_W-1:0]  regs_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              a_hit, b_hit;
    logic [DATA_W-1:0] set_m, clr_m, nxt;

    always_comb begin
      a_hit = a_we && (a_idx == IDX_W'(i));
      b_hit = b_we && (b_idx == IDX_W'(i));
      set_m = (a_hit && a_kind == RK_SET ? a_wdata : '0)
            | (b_hit && b_kind == RK_SET ? b_wdata : '0);
      clr_m = (a_hit && a_kind == RK_CLR ? a_wdata : '0)
            | (b_hit && b_kind == RK_CLR ? b_wdata : '0);
      nxt = regs_q[i];
      if (b_hit && b_kind == RK_PRI) nxt = b_wdata;
      if (a_hit && a_kind == RK_PRI) nxt = a_wdata;
      nxt = (nxt | set_m) & ~clr_m;
    end

    always_ff @(posedge clk) begin
      if (rst) regs_q[i] <= '0;
      else     regs_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/alias_rdport.sv
module alias_rdport
  import alias_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  reg_kind_e                    kind,
  input  logic [IDX_W-1:0]             idx,
  input  logic [NREG-1:0][DATA_W-1:0]  regs_q,
  output logic [DATA_W-1:0]            rdata
);
  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (kind != RK_NONE) rdata <= regs_q[idx];
    else                      rdata <= '0;
  end
endmodule

// File: rtl/alias_regs.sv
module alias_regs
  import alias_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NREG     = 8,
  parameter int PRI_BASE = 'h00,
  parameter int SET_BASE = 'h40,
  parameter int CLR_BASE = 'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int NPORTS = 2;

  logic      [NPORTS-1:0][ADDR_W-1:0] addr_p;
  logic      [NPORTS-1:0][DATA_W-1:0] rdata_p;
  reg_kind_e                          kind_p [NPORTS];
  logic      [NPORTS-1:0][IDX_W-1:0]  idx_p;
  logic      [NREG-1:0][DATA_W-1:0]   regs_q;

  assign addr_p[0] = a_addr;
  assign addr_p[1] = b_addr;
  assign a_rdata   = rdata_p[0];
  assign b_rdata   = rdata_p[1];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    alias_decode #(
      .ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W),
      .PRI_BASE(PRI_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
      .addr(addr_p[p]),
      .kind(kind_p[p]),
      .idx (idx_p[p])
    );

    alias_rdport #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rd (
      .clk   (clk),
      .rst   (rst),
      .kind  (kind_p[p]),
      .idx   (idx_p[p]),
      .regs_q(regs_q),
      .rdata (rdata_p[p])
    );
  end

  alias_bank #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .a_we   (a_we),
    .a_kind (kind_p[0]),
    .a_idx  (idx_p[0]),
    .a_wdata(a_wdata),
    .b_we   (b_we),
    .b_kind (kind_p[1]),
    .b_idx  (idx_p[1]),
    .b_wdata(b_wdata),
    .regs_q (regs_q)
  );
endmodule

// File: rtl/alias_regs_chk.sv
module alias_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NREG     = 8,
  parameter int PRI_BASE = 'h00,
  parameter int SET_BASE = 'h40,
  parameter int CLR_BASE = 'h80
) (
  input logic                         clk,
  input logic                         rst,
  input logic [ADDR_W-1:0]            a_addr,
  input logic                         a_we,
  input logic [DATA_W-1:0]            a_wdata,
  input logic [DATA_W-1:0]            a_rdata,
  input logic [ADDR_W-1:0]            b_addr,
  input logic                         b_we,
  input logic [DATA_W-1:0]            b_wdata,
  input logic [DATA_W-1:0]            b_rdata,
  input logic [NREG-1:0][DATA_W-1:0]  regs_q
);
  localparam logic [ADDR_W-1:0] N_A = ADDR_W'(NREG);

  logic [ADDR_W-1:0] a_po, a_so, a_co, b_so, b_co;
  logic              a_in_p, a_in_s, a_in_c, a_in_any, b_in_s, b_in_c;
  logic [ADDR_W-1:0] a_any;

  always_comb begin
    a_po     = a_addr - ADDR_W'(PRI_BASE);
    a_so     = a_addr - ADDR_W'(SET_BASE);
    a_co     = a_addr - ADDR_W'(CLR_BASE);
    b_so     = b_addr - ADDR_W'(SET_BASE);
    b_co     = b_addr - ADDR_W'(CLR_BASE);
    a_in_p   = a_po < N_A;
    a_in_s   = a_so < N_A;
    a_in_c   = a_co < N_A;
    b_in_s   = b_so < N_A;
    b_in_c   = b_co < N_A;
    a_in_any = a_in_p || a_in_s || a_in_c;
    a_any    = a_in_p ? a_po : (a_in_s ? a_so : a_co);
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (a_rdata == '0 && b_rdata == '0 && regs_q == '0));

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_in_s && !b_we) |=>
      regs_q[$past(a_so)] == ($past(regs_q[a_so]) | $past(a_wdata)));

  // R4
  clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_in_c && !b_we) |=>
      regs_q[$past(a_co)] == ($past(regs_q[a_co]) & ~$past(a_wdata)));

  // R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (a_we && !a_in_any && !b_we) |=> $stable(regs_q));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    !a_in_any |=> a_rdata == '0);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_in_s && b_we && b_in_c && a_so == b_co) |=>
      (regs_q[$past(b_co)] & $past(b_wdata)) == '0);

  // R8
  set_over_clear_b_chk: assert property (@(posedge clk) disable iff (rst)
    (b_we && b_in_s && a_we && a_in_c && b_so == a_co) |=>
      (regs_q[$past(a_co)] & $past(a_wdata)) == '0);

  // R9
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    a_in_any |=> a_rdata == $past(regs_q[a_any]));
endmodule

bind alias_regs alias_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
  .PRI_BASE(PRI_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst(rst),
  .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
  .regs_q(regs_q)
);

// File: tb/tb_alias_regs.sv
module tb_alias_regs;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = 8'h20;
  logic              a_we = 1'b0, b_we = 1'b0;
  logic [DATA_W-1:0] a_wdata = '0, b_wdata = '0;
  logic [DATA_W-1:0] a_rdata, b_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  alias_regs dut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 32'hA5A5_0F0F, 8'h01, 32'hA5A5_0F0F, 8'd2}, // R2 plain write
    '{8'h41, 32'h0000_F0F0, 8'h01, 32'hA5A5_FFFF, 8'd3}, // R3 set
    '{8'h81, 32'hA500_000F, 8'h01, 32'h00A5_FFF0, 8'd4}, // R4 clear
    '{8'h41, 32'h0000_0000, 8'h01, 32'h00A5_FFF0, 8'd3}, // R3 empty mask
    '{8'h81, 32'h0000_0000, 8'h41, 32'h00A5_FFF0, 8'd6}, // R6 read via set alias
    '{8'h02, 32'h1234_5678, 8'h82, 32'h1234_5678, 8'd6}, // R6 read via clear alias
    '{8'h81, 32'hFFFF_FFFF, 8'h01, 32'h0000_0000, 8'd4}, // R4 full clear
    '{8'h10, 32'hDEAD_BEEF, 8'h02, 32'h1234_5678, 8'd7}, // R7 unmapped write
    '{8'h50, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000, 8'd7}, // R7 unmapped read
    '{8'h42, 32'h0000_000F, 8'h02, 32'h1234_567F, 8'd3}, // R3 low nibble
    '{8'h03, 32'hFFFF_0000, 8'h03, 32'hFFFF_0000, 8'd2}, // R2 field setup
    '{8'h83, 32'h00FF_0000, 8'h03, 32'hFF00_0000, 8'd5}, // R5 field reads zero
    '{8'h43, 32'h005A_0000, 8'h03, 32'hFF5A_0000, 8'd5}  // R5 field value
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [7:0] ad, input logic [31:0] d);
    a_addr = ad; a_we = 1'b1; a_wdata = d;
    @(negedge clk);
    a_we = 1'b0;
  endtask

  task automatic rd_a(input logic [7:0] ad, output logic [31:0] v);
    a_addr = ad;
    @(negedge clk);
    v = a_rdata;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs zero after reset
    check("R1", a_rdata, 32'h0);
    check("R1", b_rdata, 32'h0);
    rd_a(8'h00, v);
    check("R1", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr_a(VECS[i].waddr, VECS[i].wdata);
      rd_a(VECS[i].raddr, v);
      check($sformatf("R%0d", VECS[i].req), v, VECS[i].exp);
    end

    // R8: set and clear on reg 0 in the same cycle, clear wins
    a_addr = 8'h40; a_we = 1'b1; a_wdata = 32'h0000_FFFF;
    b_addr = 8'h80; b_we = 1'b1; b_wdata = 32'h0000_00FF;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    rd_a(8'h00, v);
    check("R8", v, 32'h0000_FF00);

    // R8: plain write plus set on reg 4, set bits kept
    a_addr = 8'h04; a_we = 1'b1; a_wdata = 32'h0000_0001;
    b_addr = 8'h44; b_we = 1'b1; b_wdata = 32'h0000_0100;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    rd_a(8'h04, v);
    check("R8", v, 32'h0000_0101);

    // R8: both ports plain-write reg 6, port A kept
    a_addr = 8'h06; a_we = 1'b1; a_wdata = 32'h0000_AAAA;
    b_addr = 8'h06; b_we = 1'b1; b_wdata = 32'h0000_BBBB;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    rd_a(8'h06, v);
    check("R8", v, 32'h0000_AAAA);

    // R9: read and write of reg 5 in one cycle return the old value
    a_addr = 8'h05; a_we = 1'b1; a_wdata = 32'h0000_0077;
    @(negedge clk);
    a_we = 1'b0;
    check("R9", a_rdata, 32'h0);
    @(negedge clk);
    check("R9", a_rdata, 32'h0000_0077);

    // R6: port B reads reg 5 through its set alias
    b_addr = 8'h45;
    @(negedge clk);
    check("R6", b_rdata, 32'h0000_0077);

    // R1: reset in mid-run clears the registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", a_rdata, 32'h0);
    rd_a(8'h05, v);
    check("R1", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule